// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a configuration image into a target FPGA over a passive-serial link. A start pulse opens a session. The block first pulls the target's active-low configuration-request line low for a minimum reset pulse and confirms that the target reports reset on its active-low status line. It then releases the request and polls status at a fixed interval until the target signals readiness. After a settle delay it accepts image bytes on a valid/ready stream and shifts each one out on a data pin under a generated serial clock.

When the byte marked last has gone out, the block checks the status line and, if enabled, the done line. It then clocks out one all-zero trailer byte so that the target can start up. The session ends with a success flag or with a 3-bit error code. Both stay on the outputs until the next start. Timing values are set for two device families by a family parameter. Microsecond delays are counted with a cycles-per-microsecond parameter.

Top module: `ps_cfg_seq`

## Requirements
- R1: After reset, `cfg_n_o` is 1, `dclk_o` is 0, `busy_o`, `ok_o` and `s_ready_o` are 0, and `err_o` is 0 (no error).
- R2: A start with `partial_i` = 1 ends the session at once with `err_o` = 1 (invalid request). `cfg_n_o` never goes low and `busy_o` stays 0.
- R3: A session begins by holding `cfg_n_o` low for at least T_CFG_US microseconds (2 by default).
- R4: If `stat_n_i` is not low when the reset pulse ends, the session ends with `err_o` = 2 (no reset seen).
- R5: After releasing `cfg_n_o`, the block samples `stat_n_i` once every STAT_MIN_US (268) microseconds, up to ceil(max/268) samples, where max is 1506 µs for family 0 and 3000 µs for family 1. If `stat_n_i` never reads high, the session ends with `err_o` = 3 (not ready).
- R6: After status is seen high, no serial clock edge occurs before a settle delay of 2 µs (family 0) or 10 µs (family 1).
- R7: Each byte is sent least-significant bit first. `data_o` changes only while `dclk_o` falls or is low, and it is stable for the whole high phase of `dclk_o`. Each byte gives exactly 8 rising edges.
- R8: A byte accepted with `msb_first_i` = 1 is bit-reversed before shifting.
- R9: Bytes are sent in acceptance order, across any gaps in `s_valid_i`. `s_ready_o` is high only during streaming.
- R10: If `stat_n_i` is low after the last byte, the session ends with `err_o` = 4 (configuration error) and no trailer is sent.
- R11: With `done_en_i` = 1 and `done_i` low after the last byte, the session ends with `err_o` = 5 (done inactive) and no trailer. With `done_en_i` = 0, `done_i` is ignored.
- R12: After the checks pass, one trailer byte of value 0x00 is shifted out. Then `ok_o` = 1, `err_o` = 0 and `busy_o` = 0.
- R13: `err_o` and `ok_o` hold their final values until the next start, which clears them and raises `busy_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Session start pulse, ignored while busy |
| partial_i | input | 1 | Partial-reconfiguration request flag, sampled with start |
| msb_first_i | input | 1 | Stream bytes are MSB-first and need reversing |
| done_en_i | input | 1 | Enable the done-line check |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Marks the final byte of the image |
| s_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| cfg_n_o | output | 1 | Active-low configuration request to target |
| stat_n_i | input | 1 | Active-low status from target |
| done_i | input | 1 | Configuration-done from target |
| dclk_o | output | 1 | Generated serial clock |
| data_o | output | 1 | Serial data |
| busy_o | output | 1 | Session in progress |
| ok_o | output | 1 | Last session succeeded |
| err_o | output | 3 | Last session error code (0 none) |

## Verification
A controller stuck in the wrong state shows within a few cycles: a stream that never readies, a request line left low, or an error code set at the wrong time. Timing faults show as a reset pulse that is too short, or as a gap from request release to the first serial edge that is outside one status interval plus the settle delay. Both are measured by the bench's own model of the target. Faults in the serialiser or the reversal show as soon as the first byte is rebuilt from the pin edges. A missing or extra trailer byte shows in the byte count that a session leaves behind.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RESET, ST_WAIT, ST_SETTLE, ST_STREAM,
    ST_CHECK, ST_TRAIL, ST_DONE, ST_ERR
  } seq_state_t;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_INVALID   = 3'd1,
    E_NO_RESET  = 3'd2,
    E_NOT_READY = 3'd3,
    E_CFG       = 3'd4,
    E_DONE_LOW  = 3'd5
  } err_code_t;
endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/ps_cfg_ustick.sv
module ps_cfg_ustick #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LIM = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ps_cfg_shift.sv
module ps_cfg_shift
  import ps_cfg_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              idle_o,
  output logic              dclk_o,
  output logic              data_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(BYTE_W);
  localparam logic [DW-1:0] DLIM = DW'(DIV - 1);
  localparam logic [BW-1:0] BLAST = BW'(BYTE_W - 1);

  logic              busy_r;
  logic [BYTE_W-1:0] sr_r;
  logic [BW-1:0]     bit_r;
  logic [DW-1:0]     div_r;
  logic              dclk_r;
  logic              dout_r;

  assign idle_o = !busy_r;
  assign dclk_o = dclk_r;
  assign data_o = dout_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r <= 1'b0;
      sr_r   <= '0;
      bit_r  <= '0;
      div_r  <= '0;
      dclk_r <= 1'b0;
      dout_r <= 1'b0;
    end else if (!busy_r) begin
      dclk_r <= 1'b0;
      if (load_i) begin
        busy_r <= 1'b1;
        sr_r   <= byte_i;
        dout_r <= byte_i[0];
        bit_r  <= '0;
        div_r  <= '0;
      end
    end else if (div_r == DLIM) begin
      div_r <= '0;
      if (!dclk_r) begin
        dclk_r <= 1'b1;
      end else begin
        dclk_r <= 1'b0;
        if (bit_r == BLAST) begin
          busy_r <= 1'b0;
          dout_r <= 1'b0;
        end else begin
          bit_r  <= bit_r + 1'b1;
          sr_r   <= sr_r >> 1;
          dout_r <= sr_r[1];
        end
      end
    end else begin
      div_r <= div_r + 1'b1;
    end
  end

  p_data_stable_high_r7: assert property (@(posedge clk) disable iff (rst)
    (dclk_r && $past(dclk_r)) |-> $stable(dout_r));

  p_clk_only_busy_r7: assert property (@(posedge clk) disable iff (rst)
    dclk_r |-> busy_r);
endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import ps_cfg_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int FAMILY      = 0,
  parameter int DIV         = 2,
  parameter int T_CFG_US    = 2,
  parameter int STAT_MIN_US = 268
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              partial_i,
  input  logic              msb_first_i,
  input  logic              done_en_i,
  input  logic              s_valid_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              cfg_n_o,
  input  logic              stat_n_i,
  input  logic              done_i,
  output logic              dclk_o,
  output logic              data_o,
  output logic              busy_o,
  output logic              ok_o,
  output logic [2:0]        err_o
);
  localparam int STAT_MAX_US = (FAMILY == 1) ? 3000 : 1506;
  localparam int ST2CK_US    = (FAMILY == 1) ? 10 : 2;
  localparam int WAITS       = (STAT_MAX_US + STAT_MIN_US - 1) / STAT_MIN_US;
  localparam int US_W        = $clog2(STAT_MAX_US + 2);
  localparam int PW          = $clog2(WAITS + 1);

  seq_state_t state, nx;
  err_code_t  err_r, err_nx;
  logic       busy_r, ok_r, cfg_n_r;
  logic [US_W-1:0] us_cnt;
  logic [PW-1:0]   poll_cnt;
  logic       last_seen, trail_sent;
  logic       us_tick, tmr_clr, poll_now;
  logic       sh_load, sh_idle;
  logic [BYTE_W-1:0] sh_byte, rev_byte, in_byte;
  logic       stat_n_s, done_s;
  logic       fire;

  // input synchroniser: bit0 status (idle high), bit1 done (idle low)
  ps_cfg_sync #(.W(2), .RST_VAL(2'b01)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({done_i, stat_n_i}),
    .q_o ({done_s, stat_n_s})
  );

  ps_cfg_ustick #(.CLK_PER_US(CLK_PER_US)) i_tick (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (tmr_clr),
    .tick_o (us_tick)
  );

  ps_cfg_shift #(.DIV(DIV)) i_shift (
    .clk    (clk),
    .rst    (rst),
    .load_i (sh_load),
    .byte_i (sh_byte),
    .idle_o (sh_idle),
    .dclk_o (dclk_o),
    .data_o (data_o)
  );

  for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
    assign rev_byte[b] = s_data_i[BYTE_W-1-b];
  end

  assign in_byte   = msb_first_i ? rev_byte : s_data_i;
  assign s_ready_o = (state == ST_STREAM) && sh_idle && !last_seen;
  assign fire      = s_valid_i && s_ready_o;

  always_comb begin
    nx       = state;
    err_nx   = err_r;
    poll_now = 1'b0;
    sh_load  = 1'b0;
    sh_byte  = '0;
    case (state)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start_i) begin
          if (partial_i) begin
            nx     = ST_ERR;
            err_nx = E_INVALID;
          end else begin
            nx     = ST_RESET;
            err_nx = E_NONE;
          end
        end
      end
      ST_RESET: begin
        if (us_cnt == US_W'(T_CFG_US)) begin
          if (!stat_n_s) nx = ST_WAIT;
          else begin
            nx     = ST_ERR;
            err_nx = E_NO_RESET;
          end
        end
      end
      ST_WAIT: begin
        if (us_cnt == US_W'(STAT_MIN_US)) begin
          poll_now = 1'b1;
          if (stat_n_s) nx = ST_SETTLE;
          else if (poll_cnt == PW'(WAITS - 1)) begin
            nx     = ST_ERR;
            err_nx = E_NOT_READY;
          end
        end
      end
      ST_SETTLE: begin
        if (us_cnt == US_W'(ST2CK_US)) nx = ST_STREAM;
      end
      ST_STREAM: begin
        if (fire) begin
          sh_load = 1'b1;
          sh_byte = in_byte;
        end else if (last_seen && sh_idle) begin
          nx = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!stat_n_s) begin
          nx     = ST_ERR;
          err_nx = E_CFG;
        end else if (done_en_i && !done_s) begin
          nx     = ST_ERR;
          err_nx = E_DONE_LOW;
        end else begin
          nx = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        if (!trail_sent) sh_load = sh_idle;
        else if (sh_idle) nx = ST_DONE;
      end
      default: nx = ST_IDLE;
    endcase
  end

  assign tmr_clr = (nx != state) || poll_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      err_r   <= E_NONE;
      busy_r  <= 1'b0;
      ok_r    <= 1'b0;
      cfg_n_r <= 1'b1;
    end else begin
      state   <= nx;
      err_r   <= err_nx;
      busy_r  <= !(nx inside {ST_IDLE, ST_DONE, ST_ERR});
      ok_r    <= (nx == ST_DONE);
      cfg_n_r <= (nx != ST_RESET);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tmr_clr)                       us_cnt <= '0;
    else if (us_tick && us_cnt != {US_W{1'b1}}) us_cnt <= us_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || state != ST_WAIT) poll_cnt <= '0;
    else if (poll_now)           poll_cnt <= poll_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || state != ST_STREAM)  last_seen <= 1'b0;
    else if (fire && s_last_i)      last_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || state != ST_TRAIL) trail_sent <= 1'b0;
    else if (sh_load)             trail_sent <= 1'b1;
  end

  assign cfg_n_o = cfg_n_r;
  assign busy_o  = busy_r;
  assign ok_o    = ok_r;
  assign err_o   = err_r;

  // length of the current low phase of the request line
  logic [15:0] low_len;
  always_ff @(posedge clk) begin
    if (rst || cfg_n_o)         low_len <= '0;
    else if (low_len != 16'hFFFF) low_len <= low_len + 1'b1;
  end

  p_reset_pulse_min_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_n_o) |-> (low_len >= 16'(T_CFG_US * CLK_PER_US)));

  p_partial_no_pins_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && partial_i && !busy_o) |=> (cfg_n_o && err_o == E_INVALID && !busy_o));

  p_ready_in_session_r9: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> (busy_o && cfg_n_o));

  p_ok_clean_r12: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> (err_o == E_NONE && !busy_o && cfg_n_o));

  p_err_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(err_o) && $stable(ok_o)));
endmodule

// File: tb/test_ps_cfg_seq.sv
module test_ps_cfg_seq;
  localparam int CPU   = 2;
  localparam int WAITS = 12;
  localparam int POLLC = 268 * CPU;
  localparam int SETC  = 10 * CPU;
  localparam int NEVER = 32'h3fffffff;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, partial_i = 0, msb_first_i = 0, done_en_i = 0;
  logic s_valid_i = 0, s_last_i = 0;
  logic [7:0] s_data_i = '0;
  logic stat_n_i = 1'b1, done_i = 1'b0;
  logic s_ready_o, cfg_n_o, dclk_o, data_o, busy_o, ok_o;
  logic [2:0] err_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  int m_release = 100, rel_cnt = 0;
  bit m_ignore = 0, m_force = 0;
  int low_start = 0, low_len = 0, rise_cyc = 0, first_clk = -1, end_cyc = 0;
  logic [7:0] cap [0:31];
  logic [7:0] shreg = '0;
  int cap_n = 0, nbits = 0;
  logic [7:0] tx [0:15];

  always #2.5 clk = ~clk;

  ps_cfg_seq #(.CLK_PER_US(CPU), .FAMILY(1), .DIV(2)) i_ps_cfg_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .partial_i(partial_i),
    .msb_first_i(msb_first_i), .done_en_i(done_en_i), .s_valid_i(s_valid_i),
    .s_data_i(s_data_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
    .cfg_n_o(cfg_n_o), .stat_n_i(stat_n_i), .done_i(done_i), .dclk_o(dclk_o),
    .data_o(data_o), .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o)
  );

  // cycle counter and target model, both on the inactive edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) stat_n_i = 1'b1;
    else if (!cfg_n_o) begin
      if (!m_ignore) stat_n_i = 1'b0;
      rel_cnt = 0;
    end else if (m_force) begin
      stat_n_i = 1'b0;
      rel_cnt = 0;
    end else if (!stat_n_i) begin
      rel_cnt = rel_cnt + 1;
      if (rel_cnt >= m_release) stat_n_i = 1'b1;
    end
  end

  always @(negedge cfg_n_o) low_start = cyc;
  always @(posedge cfg_n_o) begin
    low_len  = cyc - low_start;
    rise_cyc = cyc;
  end

  always @(posedge dclk_o) begin
    shreg = {data_o, shreg[7:1]};
    nbits = nbits + 1;
    if (first_clk < 0) first_clk = cyc;
    if (nbits == 8) begin
      cap[cap_n] = shreg;
      cap_n = cap_n + 1;
      nbits = 0;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = v[7-b];
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic clear_cap();
    cap_n = 0; nbits = 0; first_clk = -1;
  endtask

  task automatic pulse_start(input bit part);
    @(negedge clk);
    start_i = 1; partial_i = part;
    @(negedge clk);
    start_i = 0; partial_i = 0;
  endtask

  task automatic feed(input int n, input bit force_after);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid_i = 1; s_data_i = tx[i]; s_last_i = (i == n - 1);
      while (!s_ready_o) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      s_valid_i = 0; s_last_i = 0;
      repeat (i % 3) @(negedge clk);
    end
    if (force_after) m_force = 1;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    end_cyc = cyc;
  endtask

  task automatic t_reset_state();
    chk("R1 cfg_n", cfg_n_o, 1);
    chk("R1 dclk", dclk_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 ok", ok_o, 0);
    chk("R1 ready", s_ready_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic t_partial();
    bit went_low = 0;
    pulse_start(1);
    repeat (20) begin
      @(negedge clk);
      if (!cfg_n_o || busy_o) went_low = 1;
    end
    chk("R2 pins untouched", went_low, 0);
    chk("R2 err code", err_o, 1);
  endtask

  task automatic t_normal(input bit msbf, input bit den, input bit dval, input int n);
    for (int i = 0; i < n; i++) tx[i] = 8'(i * 53 + 8'hA1);
    tx[0] = 8'h01;
    clear_cap();
    msb_first_i = msbf; done_en_i = den; done_i = dval; m_release = 100;
    pulse_start(0);
    feed(n, 0);
    wait_idle();
    chk_rng("R3 reset pulse cycles", low_len, 2 * CPU, 2 * CPU + 4);
    chk_rng("R6 release to first clock", first_clk - rise_cyc, POLLC + SETC, POLLC + SETC + 30);
    chk("R12 byte count", cap_n, n + 1);
    for (int i = 0; i < n; i++)
      chk(msbf ? "R8 reversed byte" : "R7 R9 byte order", cap[i], msbf ? rev8(tx[i]) : tx[i]);
    chk("R12 trailer zero", cap[n], 0);
    chk("R12 ok", ok_o, 1);
    chk(den ? "R12 err" : "R11 done ignored", err_o, 0);
  endtask

  task automatic t_no_reset();
    clear_cap();
    m_ignore = 1;
    pulse_start(0);
    wait_idle();
    chk("R4 err code", err_o, 2);
    chk("R4 cfg released", cfg_n_o, 1);
    chk("R4 no clocks", cap_n + nbits, 0);
    m_ignore = 0;
  endtask

  task automatic t_not_ready();
    clear_cap();
    m_release = NEVER;
    pulse_start(0);
    wait_idle();
    chk("R5 err code", err_o, 3);
    chk_rng("R5 window cycles", end_cyc - rise_cyc, WAITS * POLLC, WAITS * POLLC + 64);
    repeat (50) @(negedge clk);
    chk("R13 err held", err_o, 3);
    chk("R13 ok held low", ok_o, 0);
    m_release = 100;
    rel_cnt = 0;
    repeat (110) @(negedge clk);
    pulse_start(0);
    chk("R13 err cleared", err_o, 0);
    chk("R13 busy", busy_o, 1);
    tx[0] = 8'h5A;
    feed(1, 0);
    wait_idle();
    chk("R13 follow-up ok", ok_o, 1);
  endtask

  task automatic t_cfg_err();
    tx[0] = 8'hC3; tx[1] = 8'h7E;
    clear_cap();
    done_en_i = 0;
    pulse_start(0);
    feed(2, 1);
    wait_idle();
    chk("R10 err code", err_o, 4);
    chk("R10 no trailer", cap_n, 2);
    m_force = 0;
    repeat (120) @(negedge clk);
  endtask

  task automatic t_done_low();
    tx[0] = 8'h96;
    clear_cap();
    done_en_i = 1; done_i = 0;
    pulse_start(0);
    feed(1, 0);
    wait_idle();
    chk("R11 err code", err_o, 5);
    chk("R11 no trailer", cap_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_state();
    t_partial();
    t_normal(0, 1, 1, 6);
    t_normal(1, 0, 0, 4);
    t_no_reset();
    t_not_ready();
    t_cfg_err();
    t_done_low();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule